// File: doc/BRIEF.md
# Spiking Neuron Soma

This block is the cell body of a digital integrate-and-fire neuron. On every time step it takes the present output values of a bank of synapses, adds them into one excitation term, and adds that term into an 8-bit unsigned membrane potential. A value that would pass full scale saturates instead of wrapping. When no excitation arrives, the potential moves linearly back to a programmable resting level. A bounded accumulation window, opened by the first excitation, limits how long a run of near-coincident inputs may build up. If the window closes without a firing, the potential drops back to rest.

When the potential after an update is strictly greater than the programmable threshold, the block raises a one-cycle axon spike. It drives the potential to zero, which is below the resting level, and holds itself in a refractory phase for a programmable number of steps. During that phase synaptic input is ignored.

The time step is marked by a strobe. The potential can be read at all times on a readback port. Threshold, resting level, leak slope, window length and refractory length are held in configuration registers that a one-cycle write loads together.

Top module: `spk_soma`

## Requirements
- R1: After reset, the potential reads 10 and the spike output is low. The configuration registers hold these values: threshold 90, resting level 10, leak 1, window 8, refractory 2.
- R2: Synapse lane k occupies bits [4k+3:4k] of the synapse bus and is an unsigned value. The lanes are summed on the falling clock edge. The potential changes, and a spike can occur, only on a rising edge at which the step strobe is high. On any other cycle, neither the potential nor the spike output reacts to the synapse bus.
- R3: In the operational phase the candidate potential is the present potential plus the lane sum. This sum saturates at 255.
- R4: If the candidate is strictly greater than the threshold, the spike output is high for exactly the one cycle after that step, and the potential becomes 0. A candidate equal to the threshold does not fire. Firing takes priority over every other update.
- R5: A firing starts a refractory phase of max(refractory,1) steps. During these steps the potential stays 0 and synapse input is ignored. The step after the last one is operational again.
- R6: On an operational step with a lane sum of 0, no firing and no window expiry, the potential moves toward the resting level by the leak value and never crosses it. This means it goes down when above rest and up when below rest.
- R7: A step with a nonzero lane sum while no window is open opens a window. If the potential has not fired by the window-length-th step after the opening step (counting at least 1), that step sets the potential to the resting level and discards its input. The window is then closed. A firing also closes the window.
- R8: A cycle with the configuration write enable high loads all five configuration registers at once. The new values apply from the next step, and the write itself does not change the potential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Time-step strobe, one step per high cycle |
| syn_i | input | 128 | Synapse outputs, 32 lanes of 4 bits |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_thresh_i | input | 8 | Threshold to load |
| cfg_rest_i | input | 8 | Resting level to load |
| cfg_leak_i | input | 8 | Leak slope per step to load |
| cfg_frame_i | input | 8 | Accumulation window length in steps to load |
| cfg_refr_i | input | 8 | Refractory length in steps to load |
| spike_o | output | 1 | Axon spike, one cycle |
| mp_o | output | 8 | Membrane potential readback |

## Verification
The assertions assume the synapse bus is stable around the falling edge of a step cycle, so that the sum taken there is the one the following rising edge uses. They also assume that reset is held long enough for the internal synchronizer to settle. The stimulus changes the synapse bus and the strobe just after rising edges, and it drops the strobe between steps, so every step sees one clean sum. Configuration writes happen only between steps, and the refractory length used is never below 1.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic {ST_OPER = 1'b0, ST_REFR = 1'b1} soma_st_e;

  function automatic logic [7:0] sat8(input logic [15:0] v);
    return (v > 16'd255) ? 8'd255 : v[7:0];
  endfunction
endpackage

// File: rtl/spk_syn_sum.sv
module spk_syn_sum #(
  parameter int N_SYN = 32,
  parameter int SYN_W = 4,
  localparam int SUM_W = SYN_W + $clog2(N_SYN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SYN*SYN_W-1:0] syn_i,
  output logic [SUM_W-1:0]       sum_o
);
  logic [SUM_W-1:0] sum_d;
  logic [SUM_W-1:0] sum_q;

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < N_SYN; k++) begin
      sum_d = sum_d + SUM_W'(syn_i[k*SYN_W +: SYN_W]);
    end
  end

  // lanes are captured half a cycle before the step edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/spk_cfg.sv
module spk_cfg #(
  parameter int          MP_W      = 8,
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  DEF_THR   = 8'd90,
  parameter logic [7:0]  DEF_REST  = 8'd10,
  parameter logic [7:0]  DEF_LEAK  = 8'd1,
  parameter logic [7:0]  DEF_FRAME = 8'd8,
  parameter logic [7:0]  DEF_REFR  = 8'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [MP_W-1:0]  thr_i,
  input  logic [MP_W-1:0]  rest_i,
  input  logic [MP_W-1:0]  leak_i,
  input  logic [CNT_W-1:0] frame_i,
  input  logic [CNT_W-1:0] refr_i,
  output logic [MP_W-1:0]  thr_o,
  output logic [MP_W-1:0]  rest_o,
  output logic [MP_W-1:0]  leak_o,
  output logic [CNT_W-1:0] frame_o,
  output logic [CNT_W-1:0] refr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_o   <= MP_W'(DEF_THR);
      rest_o  <= MP_W'(DEF_REST);
      leak_o  <= MP_W'(DEF_LEAK);
      frame_o <= CNT_W'(DEF_FRAME);
      refr_o  <= CNT_W'(DEF_REFR);
    end else if (we_i) begin
      thr_o   <= thr_i;
      rest_o  <= rest_i;
      leak_o  <= leak_i;
      frame_o <= frame_i;
      refr_o  <= refr_i;
    end
  end
endmodule

// File: rtl/spk_core.sv
module spk_core
  import spk_pkg::*;
#(
  parameter int         MP_W     = 8,
  parameter int         CNT_W    = 8,
  parameter int         SUM_W    = 9,
  parameter logic [7:0] RST_MP   = 8'd10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [MP_W-1:0]  thr_i,
  input  logic [MP_W-1:0]  rest_i,
  input  logic [MP_W-1:0]  leak_i,
  input  logic [CNT_W-1:0] frame_i,
  input  logic [CNT_W-1:0] refr_i,
  output logic             spike_o,
  output logic [MP_W-1:0]  mp_o,
  output logic             refr_o
);
  soma_st_e         st_q, st_d;
  logic [MP_W-1:0]  mp_q, mp_d;
  logic [CNT_W-1:0] rcnt_q, rcnt_d;
  logic [CNT_W-1:0] fcnt_q, fcnt_d;
  logic             fopen_q, fopen_d;
  logic             spk_q, spk_d;
  logic [MP_W-1:0]  cand;
  logic [MP_W-1:0]  leaked;

  always_comb begin
    cand = sat8(16'(mp_q) + 16'(sum_i));
    if (mp_q > rest_i)
      leaked = ((mp_q - rest_i) > leak_i) ? mp_q - leak_i : rest_i;
    else if (mp_q < rest_i)
      leaked = ((rest_i - mp_q) > leak_i) ? mp_q + leak_i : rest_i;
    else
      leaked = rest_i;
  end

  always_comb begin
    st_d    = st_q;
    mp_d    = mp_q;
    rcnt_d  = rcnt_q;
    fcnt_d  = fcnt_q;
    fopen_d = fopen_q;
    spk_d   = 1'b0;
    if (step_i) begin
      if (st_q == ST_REFR) begin
        mp_d = '0;
        if (rcnt_q <= CNT_W'(1)) st_d = ST_OPER;
        else                     rcnt_d = rcnt_q - CNT_W'(1);
      end else if (cand > thr_i) begin
        spk_d   = 1'b1;
        mp_d    = '0;
        st_d    = ST_REFR;
        rcnt_d  = refr_i;
        fopen_d = 1'b0;
      end else if (fopen_q && fcnt_q <= CNT_W'(1)) begin
        mp_d    = rest_i;
        fopen_d = 1'b0;
      end else begin
        mp_d = (sum_i != '0) ? cand : leaked;
        if (fopen_q) begin
          fcnt_d = fcnt_q - CNT_W'(1);
        end else if (sum_i != '0) begin
          fopen_d = 1'b1;
          fcnt_d  = frame_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OPER;
      mp_q    <= MP_W'(RST_MP);
      rcnt_q  <= '0;
      fcnt_q  <= '0;
      fopen_q <= 1'b0;
      spk_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      mp_q    <= mp_d;
      rcnt_q  <= rcnt_d;
      fcnt_q  <= fcnt_d;
      fopen_q <= fopen_d;
      spk_q   <= spk_d;
    end
  end

  assign spike_o = spk_q;
  assign mp_o    = mp_q;
  assign refr_o  = (st_q == ST_REFR);
endmodule

// File: rtl/spk_soma.sv
module spk_soma #(
  parameter int N_SYN = 32,
  parameter int SYN_W = 4,
  parameter int MP_W  = 8,
  parameter int CNT_W = 8,
  localparam int SUM_W = SYN_W + $clog2(N_SYN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_i,
  input  logic [N_SYN*SYN_W-1:0] syn_i,
  input  logic                   cfg_we_i,
  input  logic [MP_W-1:0]        cfg_thresh_i,
  input  logic [MP_W-1:0]        cfg_rest_i,
  input  logic [MP_W-1:0]        cfg_leak_i,
  input  logic [CNT_W-1:0]       cfg_frame_i,
  input  logic [CNT_W-1:0]       cfg_refr_i,
  output logic                   spike_o,
  output logic [MP_W-1:0]        mp_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [SUM_W-1:0] syn_sum;
  logic [MP_W-1:0]  thr, rest, leak;
  logic [CNT_W-1:0] frame_len, refr_len;
  logic             core_refr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  spk_syn_sum #(.N_SYN(N_SYN), .SYN_W(SYN_W)) u_sum (
    .clk(clk), .rst_n(rst_sync_n), .syn_i(syn_i), .sum_o(syn_sum)
  );

  spk_cfg #(.MP_W(MP_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we_i(cfg_we_i),
    .thr_i(cfg_thresh_i), .rest_i(cfg_rest_i), .leak_i(cfg_leak_i),
    .frame_i(cfg_frame_i), .refr_i(cfg_refr_i),
    .thr_o(thr), .rest_o(rest), .leak_o(leak),
    .frame_o(frame_len), .refr_o(refr_len)
  );

  spk_core #(.MP_W(MP_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .step_i(step_i), .sum_i(syn_sum),
    .thr_i(thr), .rest_i(rest), .leak_i(leak),
    .frame_i(frame_len), .refr_i(refr_len),
    .spike_o(spike_o), .mp_o(mp_o), .refr_o(core_refr)
  );
endmodule

// File: rtl/spk_soma_chk.sv
module spk_soma_chk #(
  parameter int MP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_i,
  input logic            spike_o,
  input logic [MP_W-1:0] mp_o,
  input logic            in_refr
);
  p_no_step_spike_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> !spike_o);
  p_no_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(mp_o));
  p_fire_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |-> mp_o == '0);
  p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |=> !spike_o);
  p_fire_enters_refr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |-> in_refr);
  p_refr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_refr |-> mp_o == '0);
endmodule

bind spk_soma spk_soma_chk #(.MP_W(MP_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .step_i(step_i),
  .spike_o(spike_o), .mp_o(mp_o), .in_refr(core_refr)
);

// File: tb/spk_soma_tb.sv
`timescale 1ns/1ps
module spk_soma_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         step_i = 1'b0;
  logic [127:0] syn_i = '0;
  logic         cfg_we_i = 1'b0;
  logic [7:0]   cfg_thresh_i = '0, cfg_rest_i = '0, cfg_leak_i = '0;
  logic [7:0]   cfg_frame_i = '0, cfg_refr_i = '0;
  logic         spike_o;
  logic [7:0]   mp_o;

  int checks = 0;
  int failures = 0;

  // independent model state
  int m_mp = 10, m_thr = 90, m_rest = 10, m_leak = 1, m_frame = 8, m_refr = 2;
  bit m_refr_st = 0, m_fopen = 0;
  int m_rcnt = 0, m_fcnt = 0;

  typedef struct { bit spk; int mp; string req; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  spk_soma u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .syn_i(syn_i),
    .cfg_we_i(cfg_we_i), .cfg_thresh_i(cfg_thresh_i), .cfg_rest_i(cfg_rest_i),
    .cfg_leak_i(cfg_leak_i), .cfg_frame_i(cfg_frame_i), .cfg_refr_i(cfg_refr_i),
    .spike_o(spike_o), .mp_o(mp_o)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic exp_t model_step(input int sum, input string req);
    exp_t e;
    int cand;
    e.spk = 0; e.req = req;
    if (m_refr_st) begin
      m_mp = 0;
      if (m_rcnt <= 1) m_refr_st = 0; else m_rcnt--;
    end else begin
      cand = m_mp + sum;
      if (cand > 255) cand = 255;
      if (cand > m_thr) begin
        e.spk = 1; m_mp = 0; m_refr_st = 1; m_rcnt = m_refr; m_fopen = 0;
      end else if (m_fopen && m_fcnt <= 1) begin
        m_mp = m_rest; m_fopen = 0;
      end else begin
        if (sum != 0) m_mp = cand;
        else if (m_mp > m_rest) m_mp = (m_mp - m_rest > m_leak) ? m_mp - m_leak : m_rest;
        else if (m_mp < m_rest) m_mp = (m_rest - m_mp > m_leak) ? m_mp + m_leak : m_rest;
        if (m_fopen) m_fcnt--;
        else if (sum != 0) begin m_fopen = 1; m_fcnt = m_frame; end
      end
    end
    e.mp = m_mp;
    return e;
  endfunction

  // driver: n lanes carrying value v
  task automatic do_step(input int n, input int v, input string req);
    @(posedge clk); #1;
    syn_i = '0;
    for (int k = 0; k < n; k++) syn_i[k*4 +: 4] = 4'(v);
    step_i = 1'b1;
    sb.push_back(model_step(n * v, req));
    @(posedge clk); #1;
    step_i = 1'b0;
    syn_i = '0;
  endtask

  task automatic cfg_write(input int thr, input int rest, input int leak,
                           input int frame, input int refr);
    @(posedge clk); #1;
    cfg_we_i = 1'b1;
    cfg_thresh_i = 8'(thr); cfg_rest_i = 8'(rest); cfg_leak_i = 8'(leak);
    cfg_frame_i = 8'(frame); cfg_refr_i = 8'(refr);
    m_thr = thr; m_rest = rest; m_leak = leak; m_frame = frame; m_refr = refr;
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
  endtask

  // monitor: compare one expected item per step
  initial begin
    forever begin
      @(posedge clk);
      if (step_i === 1'b1) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          chk("scoreboard_empty", 1, 0);
        end else begin
          e = sb.pop_front();
          chk({e.req, " spike"}, int'(spike_o), int'(e.spk));
          chk({e.req, " mp"}, int'(mp_o), e.mp);
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mp_before;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset mp", int'(mp_o), 10);
    chk("R1 reset spike", int'(spike_o), 0);

    // R1 defaults used implicitly; R6 at rest
    do_step(0, 0, "R6 hold at rest");
    do_step(0, 0, "R6 hold at rest");
    do_step(4, 10, "R2 sum 40");
    do_step(5, 10, "R4 fire 100>90");
    do_step(32, 15, "R5 refractory ignores input");
    do_step(32, 15, "R5 refractory last step");
    do_step(0, 0, "R6 rise from 0");
    do_step(0, 0, "R6 rise");
    do_step(0, 0, "R6 rise");
    do_step(3, 10, "R7 open window");
    for (int i = 0; i < 8; i++) do_step(0, 0, "R7 window leak/expiry");
    do_step(0, 0, "R6 after expiry");

    // R2: bus toggles with no step, potential and spike untouched
    @(posedge clk); #1;
    mp_before = int'(mp_o);
    syn_i = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 no step mp", int'(mp_o), mp_before);
    chk("R2 no step spike", int'(spike_o), 0);
    @(posedge clk); #1 syn_i = '0;

    // R8 and R3
    cfg_write(255, 10, 5, 20, 1);
    @(negedge clk);
    chk("R8 write keeps mp", int'(mp_o), mp_before);
    do_step(32, 15, "R3 saturate 255");
    do_step(0, 0, "R8 leak 5");
    do_step(0, 0, "R8 leak 5");
    cfg_write(200, 10, 5, 20, 1);
    do_step(0, 0, "R4 fire on lowered threshold");
    do_step(0, 0, "R5 single refractory step");
    do_step(0, 0, "R6 rise by 5");
    do_step(0, 0, "R6 clamp at rest");
    do_step(0, 0, "R6 hold");
    do_step(19, 10, "R4 equal threshold no fire");
    do_step(1, 1, "R4 above threshold fires");
    do_step(0, 0, "R5 back to operational");

    cfg_write(90, 10, 1, 8, 2);
    for (int i = 0; i < 40; i++)
      do_step((i * 7) % 6, (i * 3) % 5, "R3 R6 R7 mixed pattern");

    repeat (3) @(posedge clk);
    chk("scoreboard drained", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule